// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block turns a single block-transfer request into a series of single-word bus transfers. A request gives a base address, a sixteen-bit register selection mask, and four control flags: load or store, count up or down, adjust the address before or after each transfer, and write back the updated base. The sequencer then issues one transfer per selected register. Each transfer carries the register number, a word address and a write strobe. It waits for the bus to accept each transfer, and at the end reports the adjusted base value and a write enable for it.

Registers are always laid out in memory in ascending order: the lowest-numbered selected register goes to the lowest address, and each later register goes to the next word. The up/down and before/after flags together pick one of four addressing modes. These four modes cover the usual stack conventions (full or empty, ascending or descending). A push uses one mode, and the matching pop uses the mode with both flags inverted. With write back, the base moves by four bytes for each selected register. It moves up in count-up modes and down in count-down modes.

Top module: `multi_xfer_sequencer`

## Requirements
- R1: Exactly one transfer is issued per set bit of `reg_mask`, in strictly ascending register index order on `xfer_idx`.
- R2: Each transfer's address is 4 above the previous transfer's address, so the selected registers occupy consecutive words.
- R3: In count-up modes (`up`=1), the first address is the aligned base when `pre`=0, and the aligned base + 4 when `pre`=1.
- R4: In count-down modes (`up`=0), the first address is aligned base − 4·n when `pre`=1, and aligned base − 4·n + 4 when `pre`=0, where n is the number of set mask bits.
- R5: While `xfer_valid` is high and `bus_ready` is low, `xfer_valid`, `xfer_idx` and `xfer_addr` hold their values into the next cycle.
- R6: `done` pulses for exactly one cycle after the last transfer. In that cycle, `base_new` equals aligned base + 4·n (count-up) or aligned base − 4·n (count-down), and `base_we` equals the `wback` flag given at start.
- R7: An all-zero mask produces no transfers. `done` is high in the cycle right after start, with `base_new` equal to the aligned base.
- R8: Address bits [1:0] of every transfer are zero, and base bits [1:0] have no effect on any address or on `base_new`. All arithmetic wraps modulo 2^32.
- R9: `start` and all request inputs are ignored while `busy` is high.
- R10: `xfer_write` is high during a transfer exactly when `load` was 0 at start.
- R11: After reset, `busy`, `xfer_valid`, `done` and `base_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request when idle |
| base_addr | input | 32 | Base address of the block |
| reg_mask | input | 16 | Selected registers, bit i = register i |
| load | input | 1 | 1 = read from memory, 0 = write to memory |
| up | input | 1 | 1 = count up, 0 = count down |
| pre | input | 1 | 1 = adjust before transfer, 0 = after |
| wback | input | 1 | Request base write back |
| bus_ready | input | 1 | Bus accepts the current transfer this cycle |
| xfer_valid | output | 1 | A transfer is presented |
| xfer_write | output | 1 | Transfer is a memory write |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Word address of the transfer |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| base_we | output | 1 | Write enable for the adjusted base |
| base_new | output | 32 | Adjusted base value |

## Verification
The hardest situation to reach from the ports is a bus stall in the middle of a burst that overlaps a second request trying to start. In that case the held transfer must stay frozen while new request values sit on the inputs. The stimulus covers this with a directed run that holds `start` high with a different mask and different flags for the whole burst, while `bus_ready` follows a stalling pattern. Count-down modes with a base near zero check address wrap-around. Random masks, including ones with only bit 0 or only bit 15 set, are run over all sixteen flag combinations.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
    parameter int ADDR_W     = 32;
    parameter int NUM_REGS   = 16;
    parameter int WORD_SHIFT = 2;

    typedef struct packed {
        logic load;
        logic up;
        logic pre;
        logic wb;
    } xfer_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    function automatic int unsigned word_bytes();
        return 32'd1 << WORD_SHIFT;
    endfunction
endpackage

// File: rtl/mxs_popcount.sv
module mxs_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end

    always_comb begin
        assert (int'(count) <= N) else $error("p_count_range_r1");
    end
endmodule

// File: rtl/mxs_lowest_sel.sv
module mxs_lowest_sel #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [N-1:0]  hot,
    output logic [IW-1:0] idx
);
    logic [N:0] below;

    assign below[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_scan
        assign below[g+1] = below[g] | mask[g];
        assign hot[g]     = mask[g] & ~below[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hot[i]) idx = idx | IW'(i);
        end
    end

    always_comb begin
        assert ($onehot0(hot)) else $error("p_single_pick_r1");
    end
endmodule

// File: rtl/mxs_addr_plan.sv
module mxs_addr_plan #(
    parameter int AW = 32,
    parameter int CW = 5,
    parameter int WS = 2
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam logic [AW-1:0] WORD = AW'(1) << WS;

    logic [AW-1:0] b_al;
    logic [AW-1:0] span;

    assign b_al = base & ~(WORD - AW'(1));
    assign span = AW'(cnt) << WS;

    always_comb begin
        if (up) begin
            final_base = b_al + span;
            first_addr = pre ? (b_al + WORD) : b_al;
        end else begin
            final_base = b_al - span;
            first_addr = pre ? final_base : (final_base + WORD);
        end
    end
endmodule

// File: rtl/multi_xfer_sequencer.sv
module multi_xfer_sequencer
    import mxs_pkg::*;
#(
    parameter int AW = mxs_pkg::ADDR_W,
    parameter int NR = mxs_pkg::NUM_REGS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [AW-1:0]         base_addr,
    input  logic [NR-1:0]         reg_mask,
    input  logic                  load,
    input  logic                  up,
    input  logic                  pre,
    input  logic                  wback,
    input  logic                  bus_ready,
    output logic                  xfer_valid,
    output logic                  xfer_write,
    output logic [$clog2(NR)-1:0] xfer_idx,
    output logic [AW-1:0]         xfer_addr,
    output logic                  busy,
    output logic                  done,
    output logic                  base_we,
    output logic [AW-1:0]         base_new
);
    localparam int IW = $clog2(NR);
    localparam int CW = $clog2(NR + 1);
    localparam logic [AW-1:0] WORD = AW'(word_bytes());

    seq_state_t    state;
    xfer_mode_t    mode_q;
    logic [NR-1:0] rem_mask;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] end_base;

    logic [CW-1:0] sel_cnt;
    logic [AW-1:0] first_addr;
    logic [AW-1:0] final_base;
    logic [NR-1:0] hot;
    logic [NR-1:0] next_mask;
    logic          accept;

    mxs_popcount #(.N(NR), .CW(CW)) u_count (
        .bits  (reg_mask),
        .count (sel_cnt)
    );

    mxs_addr_plan #(.AW(AW), .CW(CW), .WS(WORD_SHIFT)) u_plan (
        .base       (base_addr),
        .cnt        (sel_cnt),
        .up         (up),
        .pre        (pre),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    mxs_lowest_sel #(.N(NR), .IW(IW)) u_sel (
        .mask (rem_mask),
        .hot  (hot),
        .idx  (xfer_idx)
    );

    assign accept    = (state == ST_IDLE) && start;
    assign next_mask = rem_mask & ~hot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= '0;
            rem_mask <= '0;
            cur_addr <= '0;
            end_base <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q   <= '{load: load, up: up, pre: pre, wb: wback};
                        rem_mask <= reg_mask;
                        cur_addr <= first_addr;
                        end_base <= final_base;
                        state    <= (reg_mask == '0) ? ST_DONE : ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (bus_ready) begin
                        rem_mask <= next_mask;
                        cur_addr <= cur_addr + WORD;
                        if (next_mask == '0) state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign xfer_valid = (state == ST_MOVE);
    assign xfer_write = (state == ST_MOVE) && !mode_q.load;
    assign xfer_addr  = cur_addr;
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign base_we    = (state == ST_DONE) && mode_q.wb;
    assign base_new   = end_base;

    // R5: a stalled transfer stays frozen
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !bus_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_idx)));

    // R2: accepted transfer followed by the next word
    p_word_step_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && bus_ready) |=> (!xfer_valid || (xfer_addr == $past(xfer_addr) + WORD)));

    // R1: strictly ascending register order
    p_idx_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && bus_ready) |=> (!xfer_valid || (xfer_idx > $past(xfer_idx))));

    // R8: word alignment of every address
    p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_addr[WORD_SHIFT-1:0] == '0));

    // R6: completion is a single-cycle pulse carrying the write enable
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_we_in_done_r6: assert property (@(posedge clk) disable iff (rst)
        base_we |-> done);

    // R7: empty selection finishes on the next cycle
    p_empty_fast_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (reg_mask == '0)) |=> (done && !xfer_valid));

    // R9: a busy sequencer keeps its captured request
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(mode_q) && $stable(end_base)));

    // R10: strobe follows the captured direction
    p_write_dir_r10: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_write == !mode_q.load));
endmodule

// File: tb/sim_multi_xfer_sequencer.sv
module sim_multi_xfer_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic        load = 1'b0, up = 1'b0, pre = 1'b0, wback = 1'b0;
    logic        bus_ready = 1'b0;
    logic        xfer_valid, xfer_write, busy, done, base_we;
    logic [3:0]  xfer_idx;
    logic [31:0] xfer_addr, base_new;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    multi_xfer_sequencer u0 (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .load(load), .up(up), .pre(pre), .wback(wback),
        .bus_ready(bus_ready), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .xfer_idx(xfer_idx), .xfer_addr(xfer_addr), .busy(busy), .done(done),
        .base_we(base_we), .base_new(base_new)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int count_bits(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n,
                                              input logic u, input logic p);
        logic [31:0] a = b & ~32'd3;
        if (u) return p ? a + 32'd4 : a;
        return p ? a - 32'(4 * n) : a - 32'(4 * n) + 32'd4;
    endfunction

    function automatic logic [31:0] exp_final(input logic [31:0] b, input int n,
                                              input logic u);
        logic [31:0] a = b & ~32'd3;
        return u ? a + 32'(4 * n) : a - 32'(4 * n);
    endfunction

    // rmode: 0 always ready, 1 random, 2 long stalls
    task automatic run_op(input logic [31:0] b, input logic [15:0] m,
                          input logic ld, input logic u, input logic p,
                          input logic wb, input int rmode, input bit hold_start);
        int n = count_bits(m);
        int idxs[16];
        int k = 0;
        int cyc = 0;
        logic [31:0] first = exp_first(b, n, u, p);
        logic [31:0] fin = exp_final(b, n, u);
        string stag = u ? "R3" : "R4";
        for (int i = 0, j = 0; i < 16; i++) if (m[i]) begin idxs[j] = i; j++; end
        base_addr = b; reg_mask = m; load = ld; up = u; pre = p; wback = wb;
        start = 1'b1; bus_ready = 1'b0;
        @(negedge clk);
        if (hold_start) begin
            base_addr = ~b; reg_mask = ~m; load = ~ld; up = ~u; pre = ~p; wback = ~wb;
        end else begin
            start = 1'b0;
        end
        while (!done) begin
            if (xfer_valid) begin
                chk(k < n, "R1", "extra transfer", 32'(k), 32'(n));
                if (k < n) begin
                    chk(xfer_idx == 4'(idxs[k]), "R1", "register index", 32'(xfer_idx), 32'(idxs[k]));
                    chk(xfer_addr == first + 32'(4 * k), (k == 0) ? stag : "R2",
                        "transfer address", xfer_addr, first + 32'(4 * k));
                    chk(xfer_addr[1:0] == 2'b00, "R8", "alignment", 32'(xfer_addr[1:0]), 32'd0);
                    chk(xfer_write == !ld, "R10", "write strobe", 32'(xfer_write), 32'(!ld));
                    if (hold_start) chk(busy, "R9", "busy while start held", 32'(busy), 32'd1);
                end
                case (rmode)
                    0: bus_ready = 1'b1;
                    1: bus_ready = $urandom_range(0, 1) == 1;
                    default: bus_ready = ($urandom_range(0, 3) == 0);
                endcase
                if (bus_ready) k++;
            end else begin
                bus_ready = $urandom_range(0, 1) == 1;
                chk(1'b0, "R1", "no transfer and no done", 32'(k), 32'(n));
            end
            @(negedge clk);
            cyc++;
            if (cyc > 400) begin
                chk(1'b0, "R1", "operation timeout", 32'(cyc), 32'd400);
                break;
            end
        end
        start = 1'b0;
        bus_ready = 1'b0;
        chk(k == n, "R1", "transfer count", 32'(k), 32'(n));
        chk(base_new == fin, (n == 0) ? "R7" : "R6", "adjusted base", base_new, fin);
        chk(base_we == wb, "R6", "base write enable", 32'(base_we), 32'(wb));
        if (n == 0) chk(cyc == 0, "R7", "done latency", 32'(cyc), 32'd0);
        @(negedge clk);
        chk(!done, "R6", "done is one cycle", 32'(done), 32'd0);
        chk(!busy, "R6", "idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R11", "busy after reset", 32'(busy), 32'd0);
        chk(!xfer_valid, "R11", "valid after reset", 32'(xfer_valid), 32'd0);
        chk(!done, "R11", "done after reset", 32'(done), 32'd0);
        chk(!base_we, "R11", "base_we after reset", 32'(base_we), 32'd0);

        // directed corners
        run_op(32'h0000_1000, 16'h0025, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0); // three regs, +12
        run_op(32'h0000_2000, 16'h03FC, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0); // eight regs, +32
        run_op(32'h0000_0008, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b0); // wrap below zero
        run_op(32'h0000_0003, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0); // low base bits ignored (R8)
        run_op(32'h1234_5677, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0); // empty mask R7
        run_op(32'h0000_4000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0); // empty mask R7
        run_op(32'h0000_8000, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b0);
        run_op(32'h0000_8000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b0);
        run_op(32'h0000_3000, 16'h5A5A, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b1); // start held, R9
        run_op(32'hFFFF_FFF0, 16'h00F0, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0); // wrap above top

        // random masks over every flag combination
        for (int r = 0; r < 160; r++) begin
            logic [3:0] f = 4'(r);
            run_op($urandom, 16'($urandom), f[0], f[1], f[2], f[3],
                   $urandom_range(0, 2), (r % 23) == 5);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule